// File: doc/BRIEF.md
# PHY Register Access Handshake Engine

This block is the master side of a narrow side channel into a PHY whose 16-bit registers have no memory mapping. It drives a 20-bit control word and reads back a 17-bit status word. The control word carries a 16-bit payload and four strobes. The status word carries the PHY's read data and a single acknowledge flag. Each step of an access sets one strobe, waits for acknowledge to rise, drops the strobe and waits for acknowledge to fall.

A client places an address, write data and a read/write select on the request port and pulses the request valid. The engine sequences the address capture, then either a read or a data capture followed by a write commit. It leaves the control word at zero and reports on the response port with a one-cycle done pulse, the read data and a timeout flag.

Every acknowledge wait is bounded. The status is sampled at most `POLL_LIMIT` times, `POLL_GAP` cycles apart. If the expected level never shows, the access is abandoned, the control word is cleared and the timeout flag is raised with done.

Top module: `phy_regbus_seq`

## Requirements
- R1: The control word holds the payload in bits 15:0 and four strobes: address capture in bit 16, data capture in bit 17, write commit in bit 18 and read in bit 19. At most one strobe is set at any time.
- R2: Every access starts with an address phase. The address is driven alone for one cycle, then the address plus the address capture strobe until acknowledge (status bit 16) is 1, then the address alone until acknowledge is 0.
- R3: A read then drives only the read strobe with a zero payload until acknowledge is 1. It captures status bits 15:0 on that sample, drives the control word to zero until acknowledge is 0, and returns the captured value on the read data output.
- R4: A write then drives the data alone for one cycle and the data plus the data capture strobe until acknowledge is 1. It drives the data alone until acknowledge is 0, then only the write strobe with a zero payload until acknowledge is 1. It drives the data alone until acknowledge is 0, and finally drives the control word to zero.
- R5: Each wait samples acknowledge in its first cycle and then once every `POLL_GAP` cycles, taking at most `POLL_LIMIT` samples. With the defaults (10 samples, gap 4), a level that first shows in wait cycle 36 is accepted and one that first shows in wait cycle 37 is not.
- R6: When the last sample of a wait misses, the control word is zero for one cycle and then done and timeout are raised together. If the address capture never gets acknowledge, done arrives 3 + (POLL_LIMIT-1)*POLL_GAP cycles after the request is accepted.
- R7: Done is a one-cycle pulse, timeout is 0 on a successful access, and the control word is zero and busy is low while done is high.
- R8: A request is accepted only while busy is low. A request presented while busy has no effect on the ongoing strobe sequence or on any later state.
- R9: After reset the control word is zero and busy, done, timeout and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | With done: an acknowledge wait ran out |
| rsp_rdata | output | 16 | Data from the last successful read |
| phy_ctl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY: data 15:0, acknowledge 16 |

## Verification
Reads and writes run against a responder model whose acknowledge latency is adjustable. Short latencies check the strobe order and payload of each phase. Address and data values of all zeros, all ones and mixed bits would expose a payload driven in the wrong phase or a read sampled at the wrong time. A latency of exactly the last sample and one cycle past it separates the poll bound from an off-by-one. A responder that never raises acknowledge, and one that never drops it, place a timeout in the rise wait and in the fall wait. A request held during a write shows whether the busy guard is respected.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_SET,
        ST_ADR_CAP,
        ST_ADR_REL,
        ST_RD_STB,
        ST_RD_REL,
        ST_WD_SET,
        ST_WD_CAP,
        ST_WD_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_FIN
    } step_e;

    // strobe offsets above the payload field
    localparam int unsigned STB_CAPA = 0;
    localparam int unsigned STB_CAPD = 1;
    localparam int unsigned STB_WR   = 2;
    localparam int unsigned STB_RD   = 3;
    localparam int unsigned STB_N    = 4;

    function automatic logic step_waits(input step_e s);
        case (s)
            ST_ADR_CAP, ST_ADR_REL, ST_RD_STB, ST_RD_REL,
            ST_WD_CAP, ST_WD_REL, ST_WR_STB, ST_WR_REL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic step_want(input step_e s);
        case (s)
            ST_ADR_CAP, ST_RD_STB, ST_WD_CAP, ST_WR_STB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/phy_hs_poller.sv
module phy_hs_poller #(
    parameter int unsigned POLL_LIMIT = 10,
    parameter int unsigned POLL_GAP   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic want,
    input  logic ack,
    output logic hit,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
    localparam int unsigned GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] cnt;
    } poll_t;

    poll_t p_d, p_q;
    logic  sample;

    always_comb begin
        p_d     = p_q;
        sample  = active && (p_q.gap == '0);
        hit     = sample && (ack == want);
        expired = sample && (ack != want) && (p_q.cnt == CNT_W'(POLL_LIMIT - 1));
        if (!active || hit || expired) begin
            p_d = '0;
        end else if (sample) begin
            p_d.gap = GAP_W'(POLL_GAP - 1);
            p_d.cnt = p_q.cnt + 1'b1;
        end else begin
            p_d.gap = p_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt < CNT_W'(POLL_LIMIT)); // R5
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (p_q.cnt == '0)); // R5

endmodule

// File: rtl/phy_hs_ctl_enc.sv
module phy_hs_ctl_enc
    import phy_hs_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  step_e               step,
    input  logic [DATA_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W+3:0]   ctl
);
    logic [DATA_W-1:0] pay;
    logic [STB_N-1:0]  stb;

    always_comb begin
        pay = '0;
        stb = '0;
        case (step)
            ST_ADR_SET, ST_ADR_REL: pay = addr;
            ST_ADR_CAP: begin
                pay = addr;
                stb[STB_CAPA] = 1'b1;
            end
            ST_RD_STB: stb[STB_RD] = 1'b1;
            ST_WD_SET, ST_WD_REL, ST_WR_REL: pay = wdata;
            ST_WD_CAP: begin
                pay = wdata;
                stb[STB_CAPD] = 1'b1;
            end
            ST_WR_STB: stb[STB_WR] = 1'b1;
            default: begin
                pay = '0;
                stb = '0;
            end
        endcase
        ctl = {stb, pay};
    end

endmodule

// File: rtl/phy_regbus_seq.sv
module phy_regbus_seq
    import phy_hs_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned POLL_LIMIT = 10,
    parameter int unsigned POLL_GAP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W+3:0] phy_ctl,
    input  logic [DATA_W:0]   phy_stat
);
    localparam int unsigned ACK_BIT = DATA_W;
    localparam int unsigned STB_LO  = DATA_W;
    localparam int unsigned STB_HI  = DATA_W + STB_N - 1;

    typedef struct packed {
        step_e             step;
        logic              is_wr;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              tmo_pend;
        logic              done;
        logic              tmo;
    } seq_t;

    seq_t s_d, s_q;
    logic poll_hit, poll_exp;

    phy_hs_poller #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (step_waits(s_q.step)),
        .want    (step_want(s_q.step)),
        .ack     (phy_stat[ACK_BIT]),
        .hit     (poll_hit),
        .expired (poll_exp)
    );

    phy_hs_ctl_enc #(
        .DATA_W (DATA_W)
    ) u_enc (
        .step  (s_q.step),
        .addr  (s_q.addr),
        .wdata (s_q.wdata),
        .ctl   (phy_ctl)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.tmo  = 1'b0;
        case (s_q.step)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.step     = ST_ADR_SET;
                    s_d.is_wr    = req_write;
                    s_d.addr     = req_addr;
                    s_d.wdata    = req_wdata;
                    s_d.tmo_pend = 1'b0;
                end
            end
            ST_ADR_SET: s_d.step = ST_ADR_CAP;
            ST_WD_SET:  s_d.step = ST_WD_CAP;
            ST_FIN: begin
                s_d.step = ST_IDLE;
                s_d.done = 1'b1;
                s_d.tmo  = s_q.tmo_pend;
            end
            default: begin
                if (poll_exp) begin
                    s_d.step     = ST_FIN;
                    s_d.tmo_pend = 1'b1;
                end else if (poll_hit) begin
                    case (s_q.step)
                        ST_ADR_CAP: s_d.step = ST_ADR_REL;
                        ST_ADR_REL: s_d.step = s_q.is_wr ? ST_WD_SET : ST_RD_STB;
                        ST_RD_STB: begin
                            s_d.step  = ST_RD_REL;
                            s_d.rdata = phy_stat[DATA_W-1:0];
                        end
                        ST_RD_REL:  s_d.step = ST_FIN;
                        ST_WD_CAP:  s_d.step = ST_WD_REL;
                        ST_WD_REL:  s_d.step = ST_WR_STB;
                        ST_WR_STB:  s_d.step = ST_WR_REL;
                        ST_WR_REL:  s_d.step = ST_FIN;
                        default:    s_d.step = ST_FIN;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.step <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.step != ST_IDLE);
    assign rsp_done    = s_q.done;
    assign rsp_timeout = s_q.tmo;
    assign rsp_rdata   = s_q.rdata;

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctl[STB_HI:STB_LO])); // R1
    AST_STROBE_DROP_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phy_ctl[STB_HI:STB_LO]) != '0 && phy_ctl[STB_HI:STB_LO] == '0)
        |-> ($past(phy_stat[ACK_BIT]) || phy_ctl == '0)); // R5
    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (phy_ctl == '0 && !busy)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(s_q.addr)); // R8

endmodule

// File: tb/sim_phy_regbus_seq.sv
module sim_phy_regbus_seq;
    localparam int DW    = 16;
    localparam int LIMIT = 10;
    localparam int GAP   = 4;
    localparam int LAST  = (LIMIT - 1) * GAP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [DW-1:0] req_addr = '0, req_wdata = '0;
    logic busy, rsp_done, rsp_timeout;
    logic [DW-1:0] rsp_rdata;
    logic [DW+3:0] phy_ctl;
    logic [DW:0]   phy_stat;

    always #4 clk = ~clk;  // 125 MHz

    phy_regbus_seq #(.DATA_W(DW), .POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .phy_ctl(phy_ctl), .phy_stat(phy_stat)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- PHY responder model ----------------
    logic [DW-1:0] mem [16];
    logic [DW-1:0] ph_addr, ph_data, ph_rd;
    logic ack = 1'b0;
    int   lat = 2;
    int   cnt = 0;
    bit   dead = 0, stuck = 0;
    int   seq_code = 0;
    int   cyc = 0;
    logic [DW-1:0] cur_addr, cur_data;

    assign phy_stat = {ack, ph_rd};

    always @(posedge clk) begin
        logic [3:0] nib;
        cyc <= cyc + 1;
        nib = phy_ctl[DW+3:DW];
        if (!rst_n) begin
            ack <= 1'b0; cnt <= 0; ph_addr <= '0; ph_data <= '0; ph_rd <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'hA000 | 16'(i);
        end else if ((nib != 4'h0) != ack &&
                     ((nib != 4'h0) ? !dead : !stuck)) begin
            if (cnt >= lat) begin
                cnt <= 0;
                ack <= (nib != 4'h0);
                if (nib != 4'h0) begin
                    seq_code <= seq_code * 16 + int'(nib);
                    chk("R1 strobe one-hot", 32'($countones(nib)), 32'd1);
                    case (nib)
                        4'h1: begin ph_addr <= phy_ctl[DW-1:0];
                              chk("R2 address payload", 32'(phy_ctl[DW-1:0]), 32'(cur_addr)); end
                        4'h2: begin ph_data <= phy_ctl[DW-1:0];
                              chk("R4 data payload", 32'(phy_ctl[DW-1:0]), 32'(cur_data)); end
                        4'h4: begin mem[ph_addr[3:0]] <= ph_data;
                              chk("R4 write payload zero", 32'(phy_ctl[DW-1:0]), 32'd0); end
                        4'h8: begin ph_rd <= mem[ph_addr[3:0]];
                              chk("R3 read payload zero", 32'(phy_ctl[DW-1:0]), 32'd0); end
                        default: ;
                    endcase
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_rd;
        bit          tmo;
        logic [15:0] rdata;
        int          seq;
    } exp_t;
    exp_t sb[$];
    logic [DW-1:0] shadow [16];
    int acc_cyc = 0, done_cyc = 0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && rsp_done) chk("R7 done one cycle", 32'd1, 32'd0);
            if (rsp_done) begin
                done_cyc = cyc;
                if (sb.size() == 0) begin
                    chk("R8 unexpected completion", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tmo ? "R6 timeout flag" : "R7 no timeout", 32'(rsp_timeout), 32'(e.tmo));
                    chk("R7 ctl zero at done", 32'(phy_ctl), 32'd0);
                    chk("R2 strobe order", 32'(seq_code), 32'(e.seq));
                    if (e.is_rd && !e.tmo) chk("R3 read data", 32'(rsp_rdata), 32'(e.rdata));
                end
                seq_code = 0;
            end
            prev_done = rsp_done;
        end
    end

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input bit tmo, input int seq, input bit intrude);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.is_rd = !wr; e.tmo = tmo; e.seq = seq;
        e.rdata = shadow[a[3:0]];
        if (wr && !tmo) shadow[a[3:0]] = d;
        sb.push_back(e);
        cur_addr = a; cur_data = d;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h5555;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = 16'hA000 | 16'(i);
        repeat (3) @(negedge clk);
        chk("R9 reset ctl", 32'(phy_ctl), 32'd0);
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R9 reset done", 32'(rsp_done), 32'd0);
        chk("R9 reset timeout", 32'(rsp_timeout), 32'd0);
        chk("R9 reset rdata", 32'(rsp_rdata), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        lat = 2;
        do_op(0, 16'h0000, 16'h0000, 0, 'h18, 0);   // R3 default content
        do_op(1, 16'h0003, 16'h1234, 0, 'h124, 0);  // R4
        do_op(0, 16'h0003, 16'h0000, 0, 'h18, 0);   // R3
        do_op(1, 16'hFFFF, 16'hFFFF, 0, 'h124, 0);  // R4 all ones
        do_op(0, 16'h000F, 16'h0000, 0, 'h18, 0);
        do_op(1, 16'h0000, 16'h0000, 0, 'h124, 0);  // R4 all zero data
        do_op(0, 16'h0000, 16'h0000, 0, 'h18, 0);
        lat = 0;
        do_op(1, 16'h0009, 16'h5AA5, 0, 'h124, 0);
        do_op(0, 16'h0009, 16'h0000, 0, 'h18, 0);

        // R5: acknowledge seen on the very last sample
        lat = LAST - 1;
        do_op(1, 16'h0007, 16'hC3C3, 0, 'h124, 0);
        do_op(0, 16'h0007, 16'h0000, 0, 'h18, 0);
        // R5/R6: one cycle too late
        lat = LAST;
        do_op(1, 16'h0008, 16'h7777, 1, 'h1, 0);
        repeat (LAST + 10) @(negedge clk);
        lat = 2;
        do_op(0, 16'h0008, 16'h0000, 0, 'h18, 0);

        // R6: no acknowledge at all, check latency
        dead = 1;
        do_op(0, 16'h0002, 16'h0000, 1, 0, 0);
        chk("R6 timeout latency", 32'(done_cyc - acc_cyc), 32'(3 + LAST));
        dead = 0;
        // R6: acknowledge never falls
        stuck = 1;
        do_op(1, 16'h0004, 16'h4444, 1, 'h1, 0);
        stuck = 0;
        repeat (10) @(negedge clk);
        do_op(0, 16'h0004, 16'h0000, 0, 'h18, 0);

        // R8: request held while busy is ignored
        do_op(1, 16'h0003, 16'h1111, 0, 'h124, 1);
        repeat (5) @(negedge clk);
        chk("R8 busy stays low", 32'(busy), 32'd0);
        do_op(0, 16'h0005, 16'h0000, 0, 'h18, 0);
        do_op(0, 16'h0003, 16'h0000, 0, 'h18, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule